// File: doc/BRIEF.md
# Load-Linked Request Unit

This block serves the load half of a load-linked / store-conditional pair. A request arrives with an effective address, a size selector (word or doubleword) and a flag telling whether the core is in debug mode. The unit first tests the address for natural alignment. A misaligned request never reaches memory. It raises a one-cycle address-error-on-load exception instead, and the faulting address goes into a bad-address register, but only when the core is outside debug mode.

An aligned request records its address as the link address and then issues one single-beat read on a valid/ready read port. When the response arrives, the data is widened to 64 bits: a word is sign-extended and a doubleword passes unchanged. The widened value goes back as a one-cycle result, and the same value is kept as the link value, which marks the link as valid. Addresses are used untranslated. A clear input drops the link, for example when another agent writes the linked location. Checking a later store-conditional against the link is left to the caller.

Top module: `ll_unit`

## Requirements
- R1: A word request (`req_dword`=0) counts as misaligned when address bits [1:0] are not both zero.
- R2: A doubleword request (`req_dword`=1) counts as misaligned when address bits [2:0] are not all zero. An address that is word-aligned but not doubleword-aligned faults only for the doubleword size.
- R3: Accepting a misaligned request drives `exc_valid` high for the single following cycle. No read is issued, and no result is produced.
- R4: On a misaligned request with `req_debug`=0, `exc_badaddr` takes the request address in the same cycle as `exc_valid`. With `req_debug`=1 it keeps its previous value.
- R5: Accepting an aligned request loads `link_addr` with the request address on that clock edge. In the next cycle `mem_rd_valid` rises with `mem_rd_addr` equal to that address, and both hold steady until `mem_rd_ready` is seen.
- R6: For a word request, `res_data` is bits [31:0] of the response with bit 31 copied into bits [63:32].
- R7: For a doubleword request, `res_data` equals the 64-bit response unchanged.
- R8: `res_valid` is high for exactly the one cycle after the clock edge on which `mem_rsp_valid` is taken. On that edge `link_value` gets the same value as `res_data`, and `link_valid` is set.
- R9: `req_ready` is high only while no read is outstanding. A `req_valid` driven while `req_ready` is low is ignored.
- R10: `clr_link` high on a clock edge clears `link_valid`, and it takes priority over a response arriving on the same edge. Accepting a new aligned request also clears `link_valid` until its data returns.
- R11: A synchronous active-low reset sets `link_addr`, `link_value`, `exc_badaddr` and `res_data` to zero, clears `link_valid`, `res_valid`, `exc_valid` and `mem_rd_valid`, and leaves `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Load-linked request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_addr | input | ADDR_W | Effective (untranslated) address |
| req_dword | input | 1 | 1 = doubleword, 0 = word |
| req_debug | input | 1 | Core is in debug mode |
| clr_link | input | 1 | Invalidate the link |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | DATA_W | Read data |
| exc_valid | output | 1 | Address-error-on-load pulse |
| exc_badaddr | output | ADDR_W | Bad-address register |
| res_valid | output | 1 | Result pulse to the register file |
| res_data | output | DATA_W | Widened load result |
| link_addr | output | ADDR_W | Recorded link address |
| link_value | output | DATA_W | Recorded link value |
| link_valid | output | 1 | Link is live |

## Verification
The assertions check on every cycle that a misaligned request yields an exception and no read, and that the bad-address register follows the debug rule. They also check that a stalled read holds its address, that results last one cycle and agree with the link value, and that no request is taken while a read is outstanding. Sign extension versus pass-through, the word/doubleword boundary at address bit 2, and the way a clear interacts with a link that has just been set depend on specific data and addresses. Only the bench's scenarios, checked against an independent model of memory contents, can show those.

// File: rtl/ll_pkg.sv
// Package: shared types for the load-linked unit.
// Assumes: one outstanding read at most.
package ll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // ready for a new request
        ST_ISSUE = 2'd1,   // read request presented, waiting for ready
        ST_WAIT  = 2'd2    // read accepted, waiting for data
    } ll_state_e;

endpackage

// File: rtl/ll_align_chk.sv
// Module: natural-alignment test for word and doubleword accesses.
// Assumes: word = 4 bytes, doubleword = 8 bytes; purely combinational.
module ll_align_chk #(
    parameter int ADDR_W   = 32,
    parameter int WORD_B   = 4,
    parameter int DWORD_B  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dword,
    output logic              misaligned
);
    localparam int WLSB = $clog2(WORD_B);
    localparam int DLSB = $clog2(DWORD_B);

    logic [ADDR_W-1:0] wmask;
    logic [ADDR_W-1:0] dmask;

    // Build low-bit masks for each access size.
    always_comb begin
        wmask = '0;
        dmask = '0;
        for (int i = 0; i < WLSB; i++) wmask[i] = 1'b1;
        for (int i = 0; i < DLSB; i++) dmask[i] = 1'b1;
    end

    // Any set bit under the size mask means a misaligned address.
    always_comb begin
        misaligned = |(addr & (dword ? dmask : wmask));
    end
endmodule

// File: rtl/ll_extend.sv
// Module: widens read data to the result width.
// Assumes: word data sits in the low WORD_W bits of the response.
module ll_extend #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              dword,
    output logic [DATA_W-1:0] widened
);
    localparam int HI_W = DATA_W - WORD_W;

    logic [DATA_W-1:0] sext;

    generate
        if (HI_W > 0) begin : g_ext
            // Copy the word sign bit into all upper bits.
            always_comb sext = {{HI_W{raw[WORD_W-1]}}, raw[WORD_W-1:0]};
        end else begin : g_same
            // Word already fills the result width.
            always_comb sext = raw;
        end
    endgenerate

    // Doubleword passes through, word takes the sign-extended form.
    always_comb widened = dword ? raw : sext;
endmodule

// File: rtl/ll_ctrl.sv
// Module: request/read sequencer for the load-linked unit.
// Assumes: one read in flight; responses arrive only after the read is accepted.
module ll_ctrl
    import ll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic misaligned,
    input  logic mem_rd_ready,
    input  logic mem_rsp_valid,
    output logic req_ready,
    output logic take_fault,
    output logic take_load,
    output logic mem_rd_valid,
    output logic rsp_take
);
    ll_state_e state_q, state_d;

    // Decode the handshake events of the current cycle.
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        take_fault   = req_ready && req_valid && misaligned;
        take_load    = req_ready && req_valid && !misaligned;
        mem_rd_valid = (state_q == ST_ISSUE);
        rsp_take     = (state_q == ST_WAIT) && mem_rsp_valid;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take_load) state_d = ST_ISSUE;
            ST_ISSUE: if (mem_rd_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/ll_link_regs.sv
// Module: link, fault and result registers of the load-linked unit.
// Assumes: control events are single-cycle strobes from ll_ctrl.
module ll_link_regs #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_fault,
    input  logic              take_load,
    input  logic              rsp_take,
    input  logic              clr_link,
    input  logic              req_debug,
    input  logic              req_dword,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] load_val,
    output logic              dword_q,
    output logic [ADDR_W-1:0] rd_addr_q,
    output logic              exc_q,
    output logic [ADDR_W-1:0] bad_q,
    output logic              res_q,
    output logic [DATA_W-1:0] res_data_q,
    output logic [ADDR_W-1:0] link_addr_q,
    output logic [DATA_W-1:0] link_val_q,
    output logic              link_ok_q
);
    // Fault pulse and bad-address capture (kept unchanged in debug mode).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_q <= 1'b0;
            bad_q <= '0;
        end else begin
            exc_q <= take_fault;
            if (take_fault && !req_debug) bad_q <= req_addr;
        end
    end

    // Read address and size captured when an aligned request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr_q <= '0;
            dword_q   <= 1'b0;
        end else if (take_load) begin
            rd_addr_q <= req_addr;
            dword_q   <= req_dword;
        end
    end

    // Result pulse and data on response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q      <= 1'b0;
            res_data_q <= '0;
        end else begin
            res_q <= rsp_take;
            if (rsp_take) res_data_q <= load_val;
        end
    end

    // Link address, value and validity; a clear wins over everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_addr_q <= '0;
            link_val_q  <= '0;
            link_ok_q   <= 1'b0;
        end else begin
            if (take_load) begin
                link_addr_q <= req_addr;
                link_ok_q   <= 1'b0;
            end
            if (rsp_take) begin
                link_val_q <= load_val;
                link_ok_q  <= 1'b1;
            end
            if (clr_link) link_ok_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ll_unit.sv
// Module: load-linked unit top level.
// Checks alignment, raises address errors, issues one read per aligned
// request and keeps the link address/value. Assumes untranslated addresses.
module ll_unit #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_dword,
    input  logic              req_debug,
    input  logic              clr_link,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              exc_valid,
    output logic [ADDR_W-1:0] exc_badaddr,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [ADDR_W-1:0] link_addr,
    output logic [DATA_W-1:0] link_value,
    output logic              link_valid
);
    localparam int WORD_B  = WORD_W / 8;
    localparam int DWORD_B = DATA_W / 8;

    logic              misaligned;
    logic              take_fault;
    logic              take_load;
    logic              rsp_take;
    logic              dword_q;
    logic [DATA_W-1:0] load_val;

    ll_align_chk #(
        .ADDR_W (ADDR_W),
        .WORD_B (WORD_B),
        .DWORD_B(DWORD_B)
    ) u_align (
        .addr      (req_addr),
        .dword     (req_dword),
        .misaligned(misaligned)
    );

    ll_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .misaligned   (misaligned),
        .mem_rd_ready (mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .req_ready    (req_ready),
        .take_fault   (take_fault),
        .take_load    (take_load),
        .mem_rd_valid (mem_rd_valid),
        .rsp_take     (rsp_take)
    );

    ll_extend #(
        .DATA_W(DATA_W),
        .WORD_W(WORD_W)
    ) u_ext (
        .raw    (mem_rsp_data),
        .dword  (dword_q),
        .widened(load_val)
    );

    ll_link_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_fault (take_fault),
        .take_load  (take_load),
        .rsp_take   (rsp_take),
        .clr_link   (clr_link),
        .req_debug  (req_debug),
        .req_dword  (req_dword),
        .req_addr   (req_addr),
        .load_val   (load_val),
        .dword_q    (dword_q),
        .rd_addr_q  (mem_rd_addr),
        .exc_q      (exc_valid),
        .bad_q      (exc_badaddr),
        .res_q      (res_valid),
        .res_data_q (res_data),
        .link_addr_q(link_addr),
        .link_val_q (link_value),
        .link_ok_q  (link_valid)
    );
endmodule

// File: rtl/ll_unit_chk.sv
// Module: assertion checker for ll_unit, attached through bind.
// Assumes: observes top-level ports only.
module ll_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_dword,
    input logic              req_debug,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              exc_valid,
    input logic [ADDR_W-1:0] exc_badaddr,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic [ADDR_W-1:0] link_addr,
    input logic [DATA_W-1:0] link_value
);
    logic acc;
    logic bad;

    // Independent view of acceptance and of the alignment rule.
    always_comb begin
        acc = req_valid && req_ready;
        bad = req_dword ? (req_addr[2:0] != 3'b000) : (req_addr[1:0] != 2'b00);
    end

    // R3
    fault_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && bad |=> exc_valid && !mem_rd_valid && !res_valid);

    // R4
    badaddr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && bad && !req_debug |=> exc_badaddr == $past(req_addr));

    // R4
    badaddr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && bad && req_debug |=> $stable(exc_badaddr));

    // R5
    link_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !bad |=> mem_rd_valid && !exc_valid && link_addr == $past(req_addr)
                        && mem_rd_addr == $past(req_addr));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    // R8
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R8
    link_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> link_value == res_data);

    // R9
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);
endmodule

bind ll_unit ll_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ll_unit_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_dword   (req_dword),
    .req_debug   (req_debug),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr (mem_rd_addr),
    .exc_valid   (exc_valid),
    .exc_badaddr (exc_badaddr),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .link_addr   (link_addr),
    .link_value  (link_value)
);

// File: tb/test_ll_unit.sv
`timescale 1ns/1ps
module test_ll_unit;
    localparam int AW = 32;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_dword = 1'b0;
    logic          req_debug = 1'b0;
    logic          clr_link = 1'b0;
    logic          mem_rd_valid;
    logic          mem_rd_ready = 1'b0;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          exc_valid;
    logic [AW-1:0] exc_badaddr;
    logic          res_valid;
    logic [DW-1:0] res_data;
    logic [AW-1:0] link_addr;
    logic [DW-1:0] link_value;
    logic          link_valid;

    ll_unit i_ll_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_dword(req_dword), .req_debug(req_debug),
        .clr_link(clr_link), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .exc_valid(exc_valid), .exc_badaddr(exc_badaddr),
        .res_valid(res_valid), .res_data(res_data), .link_addr(link_addr),
        .link_value(link_value), .link_valid(link_valid)
    );

    always #4 clk = ~clk;  // 125 MHz

    typedef struct {
        bit            is_exc;
        logic [DW-1:0] val;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            n_chk = 0;
    int            n_bad = 0;
    int            cyc = 0;
    bit            done = 1'b0;
    logic [AW-1:0] model_bad = '0;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory contents model: lower word sign alternates with address bit 3.
    function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
        logic [31:0] lo;
        lo = a[3] ? (32'h8765_4321 ^ a) : (32'h1234_5678 ^ a);
        return {32'hC0DE_0000 ^ a, lo};
    endfunction

    function automatic logic [DW-1:0] widen(input logic [DW-1:0] d, input bit dw);
        if (dw) return d;
        return {{32{d[31]}}, d[31:0]};
    endfunction

    // Memory model: ready pattern, one pending read, variable latency.
    int            rdy_cnt = 0;
    bit            pend = 1'b0;
    int            dly = 0;
    logic [AW-1:0] paddr = '0;
    int            lat_sel = 0;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (dly == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = memval(paddr);
                pend = 1'b0;
            end else dly = dly - 1;
        end
        rdy_cnt++;
        mem_rd_ready = (rdy_cnt % 3) != 1;
        if (rst_n && mem_rd_valid && mem_rd_ready) begin
            pend    = 1'b1;
            paddr   = mem_rd_addr;
            dly     = 1 + (lat_sel % 3);
            lat_sel++;
        end
    end

    // Monitor: pops expected items as results or faults appear.
    always @(negedge clk) begin
        if (rst_n && !done && (res_valid || exc_valid)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R3/R9 unexpected output", {63'd0, exc_valid}, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(exc_valid == e.is_exc && res_valid == !e.is_exc, e.tag,
                    {62'd0, exc_valid, res_valid}, {62'd0, e.is_exc, !e.is_exc});
                if (e.is_exc)
                    chk(exc_badaddr == e.val[AW-1:0], {e.tag, " badaddr"},
                        {32'd0, exc_badaddr}, e.val);
                else begin
                    chk(res_data == e.val, {e.tag, " data"}, res_data, e.val);
                    chk(link_value == e.val && link_valid, "R8 link value",
                        link_value, e.val);
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Driver: one request, expectation pushed, optional busy-time poke.
    task automatic do_req(input logic [AW-1:0] a, input bit dw, input bit dbg,
                          input bit poke);
        bit   mis;
        exp_t e;
        while (!req_ready) @(negedge clk);
        mis = dw ? (a[2:0] != 0) : (a[1:0] != 0);
        if (mis) begin
            e.is_exc = 1'b1;
            if (!dbg) model_bad = a;
            e.val = {32'd0, model_bad};
            e.tag = dbg ? "R4 debug keep" : (dw ? "R2 dword fault" : "R1 word fault");
        end else begin
            e.is_exc = 1'b0;
            e.val = widen(memval(a), dw);
            e.tag = dw ? "R7 dword data" : "R6 word sext";
        end
        sb.push_back(e);
        req_valid = 1'b1; req_addr = a; req_dword = dw; req_debug = dbg;
        @(negedge clk);
        req_valid = 1'b0;
        if (!mis) begin
            chk(link_addr == a, "R5 link addr", {32'd0, link_addr}, {32'd0, a});
            chk(!link_valid, "R10 link cleared by new load", {63'd0, link_valid}, 64'd0);
            if (poke) begin
                chk(!req_ready, "R9 busy", {63'd0, req_ready}, 64'd0);
                req_valid = 1'b1; req_addr = a | 32'h1; req_dword = 1'b0;
                @(negedge clk);
                req_valid = 1'b0;
            end
        end
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(link_addr == 0 && link_value == 0 && !link_valid, "R11 link reset",
            link_value, 64'd0);
        chk(exc_badaddr == 0 && !exc_valid && !res_valid && !mem_rd_valid && req_ready,
            "R11 outputs reset", {32'd0, exc_badaddr}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        do_req(32'h0000_0100, 1'b0, 1'b0, 1'b1);   // R6 positive word
        do_req(32'h0000_0108, 1'b0, 1'b0, 1'b0);   // R6 negative word
        do_req(32'h0000_0200, 1'b1, 1'b0, 1'b1);   // R7
        do_req(32'h0000_0208, 1'b1, 1'b0, 1'b0);   // R7
        do_req(32'h0000_0101, 1'b0, 1'b0, 1'b0);   // R1
        do_req(32'h0000_0102, 1'b0, 1'b0, 1'b0);   // R1
        do_req(32'h0000_0204, 1'b1, 1'b0, 1'b0);   // R2 word-aligned dword
        do_req(32'h0000_0204, 1'b0, 1'b0, 1'b0);   // R2 same address as word is fine
        do_req(32'h0000_030C, 1'b1, 1'b1, 1'b0);   // R4 debug keeps 0x204
        do_req(32'h0000_0003, 1'b0, 1'b1, 1'b0);   // R4 debug again
        do_req(32'h0000_0006, 1'b0, 1'b0, 1'b0);   // R4 capture resumes

        // R10 clear link after a completed load
        do_req(32'h0000_0400, 1'b0, 1'b0, 1'b0);
        chk(link_valid, "R8 link valid set", {63'd0, link_valid}, 64'd1);
        clr_link = 1'b1;
        @(negedge clk);
        clr_link = 1'b0;
        chk(!link_valid, "R10 clear link", {63'd0, link_valid}, 64'd0);
        chk(link_addr == 32'h400, "R10 clear keeps addr", {32'd0, link_addr}, 64'h400);

        // Pseudo-random mix
        for (int i = 0; i < 24; i++) begin
            logic [AW-1:0] a;
            a = 32'h0000_1000 + (i * 32'h35);
            do_req(a, i[0], i[2] & i[1], i[3]);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule